// File: doc/BRIEF.md
# Translation Lookaside Cache with Software-Managed Coherence

This block keeps a small, fully associative set of recent virtual-to-physical page translations in front of a page-table walker. A requester presents a virtual page number together with the kind of access: read or write, and user or supervisor. When an entry matches, the block returns the physical page number, or a permission fault, in the same cycle. When no entry matches, the block asks the walker for the translation. A good walker answer is stored in an entry, and the lookup, which the requester holds steady, then completes from that entry. A faulting walker answer is handed straight back to the requester.

The block never snoops memory. A page-table entry that changes after it has been cached leaves the cached copy in place. Software keeps the block coherent with two controls. A single-page invalidate drops any entry for a given virtual page. A strobe that marks a write of the table root register empties the whole array. Either control also stops a walk that is in flight from installing its result, so no translation that predates the control can survive it.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid, so the first lookup of any page raises `wk_req` with `wk_vpn` equal to the looked-up page.
- R2: A lookup that matches a valid entry asserts `lk_ready` in the same cycle as `lk_valid`, returns the cached `lk_ppn`, and raises no walk request.
- R3: On a miss the block holds `wk_req` with a stable `wk_vpn` until `wk_rsp_valid`. A non-faulting answer is cached, and the pending lookup then completes from the cache without a second walk.
- R4: A hit reports `lk_fault` = 1, without walking, when a write (`lk_write` = 1) meets an entry whose writable bit is 0, or when a user access (`lk_user` = 1) meets an entry whose user bit is 0.
- R5: A walker answer with `wk_rsp_fault` = 1 asserts `lk_ready` and `lk_fault` in the same cycle and is not cached, so a repeat lookup walks again.
- R6: A change to the walker's table after a page is cached has no effect on the value the hit returns.
- R7: A pulse on `inv_valid` removes the entry whose tag equals `inv_vpn` and leaves every other entry valid.
- R8: A pulse on `root_wr` clears every entry.
- R9: A fill uses the lowest-numbered empty entry. When all entries are valid it evicts the entry at a round-robin pointer. The pointer starts at entry 0 and moves up by one, with wrap-around, after each eviction.
- R10: If a flush, or an invalidate of the page being filled, arrives in the same cycle as the walker answer, the answer is not cached and the lookup walks again.
- R11: If a flush, or an invalidate of the page being walked, arrives while a walk is outstanding, the walk's answer is not cached and the lookup walks again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request, held until lk_ready |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_write | input | 1 | Lookup is a write access |
| lk_user | input | 1 | Lookup is a user-mode access |
| lk_ready | output | 1 | Lookup completes this cycle |
| lk_fault | output | 1 | Completed lookup is a fault |
| lk_ppn | output | 20 | Physical page number of a completed, non-faulting lookup |
| wk_req | output | 1 | Walk request, held until a response arrives |
| wk_vpn | output | 20 | Page that the walker must resolve |
| wk_rsp_valid | input | 1 | Walker answer is present this cycle |
| wk_rsp_fault | input | 1 | Walker found no valid mapping |
| wk_rsp_ppn | input | 20 | Physical page from the walker |
| wk_rsp_writable | input | 1 | Page may be written |
| wk_rsp_user | input | 1 | Page may be accessed from user mode |
| inv_valid | input | 1 | Single-page invalidate strobe |
| inv_vpn | input | 20 | Page to invalidate |
| root_wr | input | 1 | Root register write strobe, flushes all entries |

## Verification
The hardest situation to reach is a coherence control landing on a walk in flight, either in the exact cycle of the walker's answer or in a cycle between request and answer. The lookup port cannot set up that timing. The bench walker model therefore carries a one-shot mode that fires an invalidate or a root write on a chosen cycle of its own response sequence. The bench then counts the walks the held lookup needs before it completes, and expects two where one would otherwise do.

// File: rtl/xlat_pkg.sv
// Shared types for the translation cache.
package xlat_pkg;

    // Access rights kept per cached page.
    typedef struct packed {
        logic writable;
        logic user;
    } perm_t;

    // Miss handling state.
    typedef enum logic {
        WK_IDLE = 1'b0,
        WK_BUSY = 1'b1
    } walk_state_e;

endpackage

// File: rtl/xlat_entry_array.sv
// Entry storage and parallel tag match for the translation cache.
// Assumes: at most one fill per cycle; flush beats invalidate beats fill on an entry.
module xlat_entry_array #(
    parameter int N     = 8,
    parameter int VPN_W = 20,
    parameter int PPN_W = 20,
    parameter int IDXW  = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [VPN_W-1:0]     lk_vpn,
    input  logic                 flush,
    input  logic                 inv_en,
    input  logic [VPN_W-1:0]     inv_vpn,
    input  logic                 fill_en,
    input  logic [IDXW-1:0]      fill_idx,
    input  logic [VPN_W-1:0]     fill_vpn,
    input  logic [PPN_W-1:0]     fill_ppn,
    input  xlat_pkg::perm_t      fill_perm,
    output logic                 hit,
    output logic [PPN_W-1:0]     hit_ppn,
    output xlat_pkg::perm_t      hit_perm,
    output logic [N-1:0]         valid_vec
);

    logic [N-1:0]       match_vec;
    logic [PPN_W-1:0]   ppn_arr  [N];
    xlat_pkg::perm_t    perm_arr [N];

    for (genvar i = 0; i < N; i++) begin : g_ent
        logic              v_q;
        logic [VPN_W-1:0]  tag_q;
        logic [PPN_W-1:0]  ppn_q;
        xlat_pkg::perm_t   perm_q;

        // Keep one entry: flush and invalidate clear it, a fill aimed here loads it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
            end else if (flush) begin
                v_q <= 1'b0;
            end else if (inv_en && v_q && (tag_q == inv_vpn)) begin
                v_q <= 1'b0;
            end else if (fill_en && (fill_idx == IDXW'(i))) begin
                v_q    <= 1'b1;
                tag_q  <= fill_vpn;
                ppn_q  <= fill_ppn;
                perm_q <= fill_perm;
            end
        end

        assign valid_vec[i] = v_q;
        assign match_vec[i] = v_q && (tag_q == lk_vpn);
        assign ppn_arr[i]   = ppn_q;
        assign perm_arr[i]  = perm_q;

        // R7: an invalidated page is gone from this entry on the next cycle.
        a_r7_inv_removes: assert property (@(posedge clk) disable iff (!rst_n)
            (inv_en && v_q && (tag_q == inv_vpn)) |=> (!v_q || (tag_q != $past(inv_vpn))));
    end

    // Select the data of the matching entry by masked OR.
    always_comb begin
        hit      = |match_vec;
        hit_ppn  = '0;
        hit_perm = '0;
        for (int i = 0; i < N; i++) begin
            if (match_vec[i]) begin
                hit_ppn  = hit_ppn | ppn_arr[i];
                hit_perm = hit_perm | perm_arr[i];
            end
        end
    end

    // R3: fills happen only on a miss, so a page never sits in two entries.
    a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    // R8: a root write empties the array.
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0));

endmodule

// File: rtl/xlat_victim.sv
// Picks the entry a fill overwrites: the lowest empty one, else a round-robin pointer.
// Assumes: fill_en pulses once per installed translation.
module xlat_victim #(
    parameter int N    = 8,
    parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     valid_vec,
    input  logic             fill_en,
    output logic [IDXW-1:0]  victim_idx
);

    localparam logic [IDXW-1:0] LAST = IDXW'(N - 1);

    logic [IDXW-1:0] ptr_q;
    logic [IDXW-1:0] first_free;
    logic            any_free;

    // Find the lowest-numbered empty entry.
    always_comb begin
        any_free   = 1'b0;
        first_free = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                any_free   = 1'b1;
                first_free = IDXW'(i);
            end
        end
    end

    assign victim_idx = any_free ? first_free : ptr_q;

    // Move the eviction pointer only when a valid entry is replaced.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (fill_en && !any_free) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    // R9: while any entry is empty, the chosen entry is an empty one.
    a_r9_empty_first: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_vec != '1) |-> !valid_vec[victim_idx]);

endmodule

// File: rtl/xlat_walk_ctrl.sv
// Miss handler: issues one walk per miss and decides whether its answer may be cached.
// Assumes: the requester holds lk_valid and lk_vpn until lk_ready.
module xlat_walk_ctrl #(
    parameter int VPN_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic              lk_hit,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic              rsp_valid,
    input  logic              flush,
    input  logic              inv_en,
    input  logic [VPN_W-1:0]  inv_vpn,
    output logic              walking,
    output logic [VPN_W-1:0]  walk_vpn,
    output logic              drop_fill
);

    xlat_pkg::walk_state_e state_q;
    logic [VPN_W-1:0]      vpn_q;
    logic                  stale_q;
    logic                  kill_now;

    assign walking   = (state_q == xlat_pkg::WK_BUSY);
    assign walk_vpn  = vpn_q;
    assign kill_now  = flush || (inv_en && (inv_vpn == vpn_q));
    assign drop_fill = stale_q || kill_now;

    // Start a walk on a miss, finish on the answer, note coherence events in between.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= xlat_pkg::WK_IDLE;
            vpn_q   <= '0;
            stale_q <= 1'b0;
        end else begin
            case (state_q)
                xlat_pkg::WK_IDLE: begin
                    if (lk_valid && !lk_hit) begin
                        state_q <= xlat_pkg::WK_BUSY;
                        vpn_q   <= lk_vpn;
                        stale_q <= 1'b0;
                    end
                end
                default: begin
                    if (rsp_valid) begin
                        state_q <= xlat_pkg::WK_IDLE;
                    end else if (kill_now) begin
                        stale_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    // R3: the walk address holds until the walker answers.
    a_r3_walk_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (walking && !rsp_valid) |=> (walking && $stable(walk_vpn)));

endmodule

// File: rtl/xlat_cache.sv
// Fully associative translation cache with per-page invalidate and flush on root write.
// Assumes: the requester holds a lookup until lk_ready; the walker answers once per request.
module xlat_cache #(
    parameter int N     = 8,
    parameter int VPN_W = 20,
    parameter int PPN_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic              lk_write,
    input  logic              lk_user,
    output logic              lk_ready,
    output logic              lk_fault,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic              wk_req,
    output logic [VPN_W-1:0]  wk_vpn,
    input  logic              wk_rsp_valid,
    input  logic              wk_rsp_fault,
    input  logic [PPN_W-1:0]  wk_rsp_ppn,
    input  logic              wk_rsp_writable,
    input  logic              wk_rsp_user,
    input  logic              inv_valid,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic              root_wr
);

    localparam int IDXW = (N > 1) ? $clog2(N) : 1;

    logic              hit;
    logic [PPN_W-1:0]  hit_ppn;
    xlat_pkg::perm_t   hit_perm;
    logic [N-1:0]      valid_vec;
    logic [IDXW-1:0]   victim_idx;
    logic              walking;
    logic              drop_fill;
    logic              fill_en;
    logic              perm_bad;
    logic              walk_fault;
    xlat_pkg::perm_t   rsp_perm;

    assign rsp_perm   = '{writable: wk_rsp_writable, user: wk_rsp_user};
    assign fill_en    = walking && wk_rsp_valid && !wk_rsp_fault && !drop_fill;
    assign walk_fault = walking && wk_rsp_valid && wk_rsp_fault;
    assign perm_bad   = (lk_write && !hit_perm.writable) || (lk_user && !hit_perm.user);

    // Complete a lookup from a hit, or from a faulting walker answer.
    always_comb begin
        lk_ready = lk_valid && ((!walking && hit) || walk_fault);
        lk_fault = hit ? perm_bad : walk_fault;
        lk_ppn   = (hit && !perm_bad) ? hit_ppn : '0;
    end

    assign wk_req = walking;

    xlat_entry_array #(.N(N), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDXW(IDXW)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_vpn    (lk_vpn),
        .flush     (root_wr),
        .inv_en    (inv_valid),
        .inv_vpn   (inv_vpn),
        .fill_en   (fill_en),
        .fill_idx  (victim_idx),
        .fill_vpn  (wk_vpn),
        .fill_ppn  (wk_rsp_ppn),
        .fill_perm (rsp_perm),
        .hit       (hit),
        .hit_ppn   (hit_ppn),
        .hit_perm  (hit_perm),
        .valid_vec (valid_vec)
    );

    xlat_victim #(.N(N), .IDXW(IDXW)) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_vec  (valid_vec),
        .fill_en    (fill_en),
        .victim_idx (victim_idx)
    );

    xlat_walk_ctrl #(.VPN_W(VPN_W)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_valid  (lk_valid),
        .lk_hit    (hit),
        .lk_vpn    (lk_vpn),
        .rsp_valid (wk_rsp_valid),
        .flush     (root_wr),
        .inv_en    (inv_valid),
        .inv_vpn   (inv_vpn),
        .walking   (walking),
        .walk_vpn  (wk_vpn),
        .drop_fill (drop_fill)
    );

    // R2: a hit while idle never starts a walk.
    a_r2_hit_no_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (!walking && lk_valid && hit) |=> !wk_req);

    // R5: a faulting walker answer never adds a valid entry.
    a_r5_fault_not_cached: assert property (@(posedge clk) disable iff (!rst_n)
        (wk_rsp_valid && wk_rsp_fault) |=> ($countones(valid_vec) <= $past($countones(valid_vec))));

    // R10: a root write in the answer cycle leaves nothing cached.
    a_r10_flush_beats_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (walking && wk_rsp_valid && root_wr) |=> (valid_vec == '0));

endmodule

// File: tb/xlat_cache_test.sv
// Scoreboard bench: lookups push expected results, a monitor pops and compares them.
module xlat_cache_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic        lk_write = 1'b0;
    logic        lk_user = 1'b0;
    logic        lk_ready, lk_fault;
    logic [19:0] lk_ppn;
    logic        wk_req;
    logic [19:0] wk_vpn;
    logic        wk_rsp_valid = 1'b0;
    logic        wk_rsp_fault = 1'b0;
    logic [19:0] wk_rsp_ppn = '0;
    logic        wk_rsp_writable = 1'b0;
    logic        wk_rsp_user = 1'b0;
    logic        t_inv = 1'b0, m_inv = 1'b0;
    logic [19:0] t_inv_vpn = '0, m_inv_vpn = '0;
    logic        t_root = 1'b0, m_root = 1'b0;
    logic        inv_valid, root_wr;
    logic [19:0] inv_vpn;

    assign inv_valid = t_inv | m_inv;
    assign inv_vpn   = m_inv ? m_inv_vpn : t_inv_vpn;
    assign root_wr   = t_root | m_root;

    always #10 clk = ~clk;   // 50 MHz

    xlat_cache uut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_write(lk_write), .lk_user(lk_user),
        .lk_ready(lk_ready), .lk_fault(lk_fault), .lk_ppn(lk_ppn),
        .wk_req(wk_req), .wk_vpn(wk_vpn),
        .wk_rsp_valid(wk_rsp_valid), .wk_rsp_fault(wk_rsp_fault), .wk_rsp_ppn(wk_rsp_ppn),
        .wk_rsp_writable(wk_rsp_writable), .wk_rsp_user(wk_rsp_user),
        .inv_valid(inv_valid), .inv_vpn(inv_vpn), .root_wr(root_wr)
    );

    int nchk = 0;
    int nfail = 0;
    int walks = 0;
    int mode = 0;     // 1: inv at answer, 2: root at answer, 3: inv mid-walk
    int wcnt = 0;
    int cycles = 0;

    // Walker's page table model, indexed by the low six page bits.
    logic [19:0] pt_ppn [64];
    logic        pt_w   [64];
    logic        pt_u   [64];
    logic        pt_f   [64];

    // Scoreboard queues.
    logic  q_fault [$];
    logic [19:0] q_ppn [$];
    string q_req [$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compare each completed lookup with the oldest expected item.
    always @(negedge clk) begin
        if (lk_valid && lk_ready) begin
            if (q_req.size() == 0) begin
                chk(1'b0, "unexpected completion", 0, 1);
            end else begin
                logic  ef;
                logic [19:0] ep;
                string rq;
                ef = q_fault.pop_front();
                ep = q_ppn.pop_front();
                rq = q_req.pop_front();
                chk(lk_fault == ef, {rq, " fault"}, int'(lk_fault), int'(ef));
                if (!ef) chk(lk_ppn == ep, {rq, " ppn"}, int'(lk_ppn), int'(ep));
            end
        end
    end

    // Walker model: answers two cycles after the request, with optional coherence events.
    initial begin
        forever begin
            @(posedge clk); #1;
            wk_rsp_valid = 1'b0; m_inv = 1'b0; m_root = 1'b0;
            if (wk_req) begin
                wcnt++;
                if (wcnt == 1 && mode == 3) begin
                    m_inv = 1'b1; m_inv_vpn = wk_vpn; mode = 0;
                end
                if (wcnt == 2) begin
                    wk_rsp_valid    = 1'b1;
                    wk_rsp_ppn      = pt_ppn[wk_vpn[5:0]];
                    wk_rsp_writable = pt_w[wk_vpn[5:0]];
                    wk_rsp_user     = pt_u[wk_vpn[5:0]];
                    wk_rsp_fault    = pt_f[wk_vpn[5:0]];
                    walks++;
                    wcnt = 0;
                    if (mode == 1) begin m_inv = 1'b1; m_inv_vpn = wk_vpn; end
                    if (mode == 2) m_root = 1'b1;
                    mode = 0;
                end
            end else begin
                wcnt = 0;
            end
        end
    end

    // Drive one lookup, expect a result, and check walk count and latency.
    task automatic lookup(input int v, input bit wr, input bit us, input int exp_walks,
                          input bit ef, input logic [19:0] ep, input string req);
        int w0;
        int waitc;
        w0 = walks;
        waitc = 0;
        q_fault.push_back(ef); q_ppn.push_back(ep); q_req.push_back(req);
        @(posedge clk); #1;
        lk_valid = 1'b1; lk_vpn = 20'(v); lk_write = wr; lk_user = us;
        forever begin
            @(negedge clk);
            if (lk_ready) break;
            waitc++;
        end
        @(posedge clk); #1;
        lk_valid = 1'b0;
        chk(walks - w0 == exp_walks, {req, " walks"}, walks - w0, exp_walks);
        if (exp_walks == 0) chk(waitc == 0, {req, " same-cycle"}, waitc, 0);
    endtask

    task automatic pulse_inv(input int v);
        @(posedge clk); #1; t_inv = 1'b1; t_inv_vpn = 20'(v);
        @(posedge clk); #1; t_inv = 1'b0;
    endtask

    task automatic pulse_root();
        @(posedge clk); #1; t_root = 1'b1;
        @(posedge clk); #1; t_root = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                nfail++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
                $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
                $finish;
            end
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            pt_ppn[i] = 20'h80000 | 20'(i * 7);
            pt_w[i] = 1'b1; pt_u[i] = 1'b1; pt_f[i] = 1'b0;
        end
        pt_w[2] = 1'b0; pt_u[3] = 1'b0; pt_f[4] = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!wk_req && !lk_ready, "R1 reset idle", int'(wk_req), 0);

        // R1, R3: first lookup walks and fills; R2: repeat hits same cycle.
        lookup(1, 0, 0, 1, 0, pt_ppn[1], "R1 R3 first miss");
        lookup(1, 0, 1, 0, 0, pt_ppn[1], "R2 hit");
        // R4: permission faults on cached entries.
        lookup(2, 0, 1, 1, 0, pt_ppn[2], "R3 fill read-only");
        lookup(2, 1, 0, 0, 1, 0, "R4 write to read-only");
        lookup(3, 0, 1, 1, 1, 0, "R4 user to supervisor");
        lookup(3, 1, 0, 0, 0, pt_ppn[3], "R4 supervisor ok");
        // R5: walker fault passes through, not cached.
        lookup(4, 0, 0, 1, 1, 0, "R5 walker fault");
        lookup(4, 0, 0, 1, 1, 0, "R5 fault rewalk");
        // R6: table change invisible to cached entry.
        pt_ppn[1] = 20'h12345;
        lookup(1, 0, 0, 0, 0, 20'h80007, "R6 stale copy kept");
        // R7: invalidate one page only.
        pulse_inv(1);
        lookup(1, 0, 0, 1, 0, 20'h12345, "R7 invalidated walks");
        lookup(2, 0, 0, 0, 0, pt_ppn[2], "R7 other page kept");
        // R9: empty entries first, then round-robin from entry 0.
        pulse_root();
        for (int v = 10; v < 18; v++) lookup(v, 0, 0, 1, 0, pt_ppn[v], "R9 fill empty");
        lookup(18, 0, 0, 1, 0, pt_ppn[18], "R9 evict entry0");
        lookup(11, 0, 0, 0, 0, pt_ppn[11], "R9 entry1 kept");
        lookup(10, 0, 0, 1, 0, pt_ppn[10], "R9 evicted page walks");
        lookup(11, 0, 0, 1, 0, pt_ppn[11], "R9 pointer advanced");
        lookup(13, 0, 0, 0, 0, pt_ppn[13], "R9 entry3 kept");
        // R8: flush drops every entry.
        pulse_root();
        lookup(13, 0, 0, 1, 0, pt_ppn[13], "R8 flushed page walks");
        lookup(18, 0, 0, 1, 0, pt_ppn[18], "R8 flushed page2 walks");
        // R10: coherence event in the answer cycle.
        mode = 1;
        lookup(20, 0, 0, 2, 0, pt_ppn[20], "R10 inv at answer");
        lookup(20, 0, 0, 0, 0, pt_ppn[20], "R10 refill hits");
        mode = 2;
        lookup(21, 0, 0, 2, 0, pt_ppn[21], "R10 flush at answer");
        lookup(13, 0, 0, 1, 0, pt_ppn[13], "R10 flush cleared all");
        // R11: invalidate during an outstanding walk.
        mode = 3;
        lookup(22, 0, 0, 2, 0, pt_ppn[22], "R11 inv mid-walk");
        lookup(22, 0, 0, 0, 0, pt_ppn[22], "R11 refill hits");

        repeat (2) @(posedge clk);
        chk(q_req.size() == 0, "scoreboard drained", q_req.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule